// File: doc/BRIEF.md
# UART Receive Queue with Idle-Data Timeout

This block is the receive-side character queue of a UART channel. The deserialiser hands it each completed character with a one-cycle write strobe. The host takes characters from the head of the queue with a read strobe. The queue holds up to sixteen characters. When the queue is switched off, it shrinks to a single holding slot. It raises a level request once the number of stored characters reaches a selectable threshold. It keeps accepting characters past that threshold until it is full.

A separate timer guards against characters that sit unread below the threshold. It counts bit-time ticks while the queue holds data. The timer is a three-state machine:

- `T_IDLE`: the queue is empty and the counter is held at zero. A non-empty queue moves it to `T_RUN`.
- `T_RUN`: counting. It moves to `T_FIRE` on the tick that reaches the limit, and back to `T_IDLE` if the queue empties.
- `T_FIRE`: the timeout request is raised. A host read or a stop-bit-centre strobe moves it back to `T_RUN`, and an empty queue moves it to `T_IDLE`.

While the machine is in `T_RUN`, any restart event zeroes the counter. The limit depends on the programmed data word length P and is 4·P + 12 bit times.

Top module: `rx_fifo_tmo`

## Requirements
- R1: Characters leave in the order they were accepted. `rd_data` always presents the oldest stored character and reads 0 when the queue is empty. With `fifo_en`=1 up to 16 characters are held.
- R2: `data_rdy` is 1 exactly while `fill` is non-zero. It stays 1 after a read as long as characters remain.
- R3: With `fifo_en`=0 the queue holds at most one character. A second write without an intervening read is dropped.
- R4: A write arriving when the queue is full (and no read happens in the same cycle) is discarded and sets `overrun`. `overrun` stays set until a `stat_rd` pulse clears it. A new drop in the same cycle takes precedence over the clear.
- R5: `trig_sel` encodes the threshold: 0→1, 1→4, 2→8, 3→14 characters (in single-slot mode the threshold is 1). `trig_req` is 1 while `fill` is at or above the threshold.
- R6: `wlen` encodes P = 5, 6, 7, 8 for 0, 1, 2, 3. `tmo_req` rises on the (4·P+12)-th `bit_tick` counted after the queue became non-empty or after the last restart. That is 32, 36, 40 or 44 ticks.
- R7: A `stop_ctr` pulse or a host `rd_en` pulse restarts the count from zero.
- R8: `tmo_req` is never 1 while the queue is empty, however many ticks arrive.
- R9: An active `tmo_req` drops in the cycle after a host read or a `stop_ctr` pulse.
- R10: Changing `fifo_en` empties the queue in the following cycle. A write in that same cycle is discarded.
- R11: A read strobe on an empty queue has no effect on the count or the pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Received-character strobe |
| wr_data | input | 8 | Received character |
| stop_ctr | input | 1 | Pulse at the centre of each received stop bit |
| bit_tick | input | 1 | One pulse per bit time |
| wlen | input | 2 | Data word length code (5..8 bits) |
| trig_sel | input | 2 | Threshold code (1, 4, 8, 14) |
| fifo_en | input | 1 | 1: sixteen-entry queue, 0: single slot |
| rd_en | input | 1 | Host read of the head character |
| stat_rd | input | 1 | Host read of status, clears `overrun` |
| rd_data | output | 8 | Head character |
| data_rdy | output | 1 | At least one character stored |
| fill | output | 5 | Number of stored characters |
| trig_req | output | 1 | Threshold reached |
| tmo_req | output | 1 | Unread-data timeout |
| overrun | output | 1 | A character was dropped |

## Verification
A corrupted pointer or count shows up at the ports at once. The next read returns a character out of order, or `fill` disagrees with the number of accepted writes. `data_rdy` and `trig_req` follow that wrong count in the same cycle. A timer that miscounts or restarts at the wrong time moves the rising edge of `tmo_req` away from the exact tick number. The bench therefore checks that edge one tick early and on the exact tick, for three word lengths. The bench also checks that a timer left running on an empty queue never raises `tmo_req`, even after long runs of ticks.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [1:0] {
        T_IDLE = 2'd0,
        T_RUN  = 2'd1,
        T_FIRE = 2'd2
    } tmo_state_e;

    // threshold code -> characters
    function automatic int trig_level(input logic [1:0] sel);
        int lvl;
        unique case (sel)
            2'd0:    lvl = 1;
            2'd1:    lvl = 4;
            2'd2:    lvl = 8;
            default: lvl = 14;
        endcase
        return lvl;
    endfunction

    // word length code -> timeout in bit times: 4*(code+5)+12
    function automatic int tmo_limit(input logic [1:0] wl);
        return 4 * (int'(wl) + 5) + 12;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic          stat_rd,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count,
    output logic          overrun
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          mode_q;
    logic          ovr;
    logic [CW-1:0] cap;
    logic          flush, rd_go, wr_go, wr_drop;

    always_comb begin
        cap     = fifo_en ? CW'(DEPTH) : CW'(1);
        flush   = (fifo_en != mode_q);
        rd_go   = rd_en && (cnt != '0) && !flush;
        wr_go   = wr_en && !flush && ((cnt < cap) || rd_go);
        wr_drop = wr_en && !flush && !wr_go;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp     <= '0;
            rp     <= '0;
            cnt    <= '0;
            mode_q <= 1'b0;
            ovr    <= 1'b0;
        end else begin
            mode_q <= fifo_en;
            if (flush) begin
                wp  <= '0;
                rp  <= '0;
                cnt <= '0;
            end else begin
                if (wr_go) wp <= wp + AW'(1);
                if (rd_go) rp <= rp + AW'(1);
                unique case ({wr_go, rd_go})
                    2'b10:   cnt <= cnt + CW'(1);
                    2'b01:   cnt <= cnt - CW'(1);
                    default: cnt <= cnt;
                endcase
            end
            if (wr_drop)      ovr <= 1'b1;
            else if (stat_rd) ovr <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_go) mem[wp] <= wr_data;
    end

    assign rd_data = (cnt == '0) ? '0 : mem[rp];
    assign count   = cnt;
    assign overrun = ovr;

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R4
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush && (cnt == cap) && !rd_go) |=> ovr);

    // R10
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt == '0));

    // R1
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && !rd_go) |=> (cnt == $past(cnt) + CW'(1)));

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer
    import rxq_pkg::*;
#(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_tick,
    input  logic          restart,
    input  logic          empty,
    input  logic [TW-1:0] limit,
    output logic          tmo_req
);

    tmo_state_e    state, nxt;
    logic [TW-1:0] tc, tc_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= T_IDLE;
            tc    <= '0;
        end else begin
            state <= nxt;
            tc    <= tc_n;
        end
    end

    always_comb begin
        nxt  = state;
        tc_n = tc;
        unique case (state)
            T_IDLE: begin
                tc_n = '0;
                if (!empty) nxt = T_RUN;
            end
            T_RUN: begin
                if (empty) begin
                    nxt  = T_IDLE;
                    tc_n = '0;
                end else if (restart) begin
                    tc_n = '0;
                end else if (bit_tick) begin
                    if (tc >= limit - TW'(1)) begin
                        nxt  = T_FIRE;
                        tc_n = '0;
                    end else begin
                        tc_n = tc + TW'(1);
                    end
                end
            end
            T_FIRE: begin
                tc_n = '0;
                if (empty)        nxt = T_IDLE;
                else if (restart) nxt = T_RUN;
            end
            default: begin
                nxt  = T_IDLE;
                tc_n = '0;
            end
        endcase
    end

    always_comb begin
        tmo_req = (state == T_FIRE) && !empty;
    end

    // R8
    quiet_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |=> (state != T_FIRE));

    // R7
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == T_RUN && !empty && restart) |=> (state == T_RUN && tc == '0));

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == T_FIRE && restart) |=> !tmo_req);

endmodule

// File: rtl/rx_fifo_tmo.sv
module rx_fifo_tmo
    import rxq_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int TW    = 6,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          stop_ctr,
    input  logic          bit_tick,
    input  logic [1:0]    wlen,
    input  logic [1:0]    trig_sel,
    input  logic          fifo_en,
    input  logic          rd_en,
    input  logic          stat_rd,
    output logic [DW-1:0] rd_data,
    output logic          data_rdy,
    output logic [CW-1:0] fill,
    output logic          trig_req,
    output logic          tmo_req,
    output logic          overrun
);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lvl;
    logic [TW-1:0] limit;

    rxq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .fifo_en (fifo_en),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .stat_rd (stat_rd),
        .rd_data (rd_data),
        .count   (cnt),
        .overrun (overrun)
    );

    always_comb begin
        lvl   = fifo_en ? CW'(trig_level(trig_sel)) : CW'(1);
        limit = TW'(tmo_limit(wlen));
    end

    rxq_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .restart  (stop_ctr || rd_en),
        .empty    (cnt == '0),
        .limit    (limit),
        .tmo_req  (tmo_req)
    );

    assign fill     = cnt;
    assign data_rdy = (cnt != '0);
    assign trig_req = (cnt >= lvl);

endmodule

// File: tb/sim_rx_fifo_tmo.sv
`timescale 1ns/1ps
module sim_rx_fifo_tmo;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       stop_ctr = 1'b0;
    logic       bit_tick = 1'b0;
    logic [1:0] wlen = 2'd2;
    logic [1:0] trig_sel = 2'd1;
    logic       fifo_en = 1'b1;
    logic       rd_en = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] rd_data;
    logic       data_rdy;
    logic [4:0] fill;
    logic       trig_req, tmo_req, overrun;

    int nchk = 0;
    int nerr = 0;
    logic [7:0] exp_q [$];

    always #2 clk = ~clk;

    rx_fifo_tmo u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .stop_ctr(stop_ctr), .bit_tick(bit_tick), .wlen(wlen),
        .trig_sel(trig_sel), .fifo_en(fifo_en), .rd_en(rd_en),
        .stat_rd(stat_rd), .rd_data(rd_data), .data_rdy(data_rdy),
        .fill(fill), .trig_req(trig_req), .tmo_req(tmo_req),
        .overrun(overrun)
    );

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: pushes expected characters into the scoreboard
    task automatic push(logic [7:0] d, bit acc);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (acc) exp_q.push_back(d);
    endtask

    task automatic pop();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic tick(int n);
        repeat (n) begin
            @(negedge clk);
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
        end
    endtask

    task automatic stop_pulse();
        @(negedge clk);
        stop_ctr = 1'b1;
        @(negedge clk);
        stop_ctr = 1'b0;
    endtask

    task automatic stat_pulse();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    // monitor: compares each read head with the scoreboard (R1)
    always @(negedge clk) begin
        #1;
        if (rd_en && exp_q.size() > 0) begin
            chk("R1 head order", int'(rd_data), int'(exp_q.pop_front()));
        end
    end

    initial begin
        #400000;
        nerr++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        // reset state
        chk("R2 reset data_rdy", int'(data_rdy), 0);
        chk("R2 reset fill", int'(fill), 0);
        chk("R5 reset trig", int'(trig_req), 0);
        chk("R8 reset tmo", int'(tmo_req), 0);
        chk("R4 reset overrun", int'(overrun), 0);

        // thresholds, R5
        for (int i = 0; i < 3; i++) push(8'h40 + 8'(i), 1'b1);
        chk("R5 fill 3", int'(fill), 3);
        chk("R5 below 4", int'(trig_req), 0);
        push(8'h43, 1'b1);
        chk("R5 at 4", int'(trig_req), 1);
        trig_sel = 2'd2;
        cyc(1);
        chk("R5 sel8 at 4", int'(trig_req), 0);
        for (int i = 4; i < 8; i++) push(8'h40 + 8'(i), 1'b1);
        chk("R5 at 8", int'(trig_req), 1);
        trig_sel = 2'd3;
        cyc(1);
        chk("R5 sel14 at 8", int'(trig_req), 0);
        for (int i = 8; i < 13; i++) push(8'h40 + 8'(i), 1'b1);
        chk("R5 at 13", int'(trig_req), 0);
        push(8'h4D, 1'b1);
        chk("R5 at 14", int'(trig_req), 1);
        push(8'h4E, 1'b1);
        push(8'h4F, 1'b1);
        chk("R1 full 16", int'(fill), 16);

        // overrun, R4
        push(8'hEE, 1'b0);
        chk("R4 drop fill", int'(fill), 16);
        chk("R4 overrun set", int'(overrun), 1);
        stat_pulse();
        chk("R4 overrun clear", int'(overrun), 0);

        // drain, R2 / R1
        for (int i = 0; i < 15; i++) pop();
        chk("R2 rdy with one left", int'(data_rdy), 1);
        chk("R2 fill one", int'(fill), 1);
        pop();
        chk("R2 rdy empty", int'(data_rdy), 0);
        chk("R1 rd_data empty", int'(rd_data), 0);

        // read on empty, R11
        pop();
        chk("R11 fill after empty read", int'(fill), 0);
        push(8'hA5, 1'b1);
        chk("R11 head after empty read", int'(rd_data), 8'hA5);
        pop();

        // timeout P=7 -> 40, R6
        wlen = 2'd2;
        push(8'h11, 1'b1);
        cyc(1);
        tick(39);
        chk("R6 wl7 at 39", int'(tmo_req), 0);
        tick(1);
        chk("R6 wl7 at 40", int'(tmo_req), 1);
        chk("R5 below level while timeout", int'(trig_req), 0);
        stop_pulse();
        chk("R9 cleared by stop", int'(tmo_req), 0);
        tick(39);
        chk("R7 stop restart at 39", int'(tmo_req), 0);
        tick(1);
        chk("R7 stop restart at 40", int'(tmo_req), 1);
        push(8'h12, 1'b1);
        pop();
        chk("R9 cleared by read", int'(tmo_req), 0);
        chk("R2 fill after read", int'(fill), 1);
        tick(39);
        chk("R7 read restart at 39", int'(tmo_req), 0);
        tick(1);
        chk("R7 read restart at 40", int'(tmo_req), 1);
        pop();
        chk("R8 empty after read", int'(tmo_req), 0);
        tick(60);
        chk("R8 no timeout when empty", int'(tmo_req), 0);

        // P=5 -> 32
        wlen = 2'd0;
        push(8'h21, 1'b1);
        cyc(1);
        tick(31);
        chk("R6 wl5 at 31", int'(tmo_req), 0);
        tick(1);
        chk("R6 wl5 at 32", int'(tmo_req), 1);
        pop();

        // P=8 -> 44
        wlen = 2'd3;
        push(8'h22, 1'b1);
        cyc(1);
        tick(43);
        chk("R6 wl8 at 43", int'(tmo_req), 0);
        tick(1);
        chk("R6 wl8 at 44", int'(tmo_req), 1);
        pop();

        // mode change flush, R10
        push(8'h50, 1'b1);
        push(8'h51, 1'b1);
        chk("R10 fill before", int'(fill), 2);
        fifo_en = 1'b0;
        cyc(1);
        chk("R10 flushed", int'(fill), 0);
        exp_q.delete();

        // single slot, R3
        push(8'h61, 1'b1);
        chk("R3 one stored", int'(fill), 1);
        chk("R5 single-slot trig", int'(trig_req), 1);
        push(8'h62, 1'b0);
        chk("R3 second dropped", int'(fill), 1);
        chk("R3 overrun", int'(overrun), 1);
        chk("R3 head kept", int'(rd_data), 8'h61);
        pop();
        chk("R3 empty after read", int'(fill), 0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule